// File: doc/BRIEF.md
# HDLC Normal-Response-Mode Secondary Transmit Controller

This block decides when an HDLC secondary station in normal response mode may transmit, and it keeps track of whether the frame it sent has been acknowledged. The receive side decodes each incoming frame and hands the block one event per frame. Each event carries the frame kind (RR, RNR, REJ or I), the poll/final bit, the N(R) field and the destination address. The host queues a single I-frame with a one-cycle request. The block then waits until the primary polls it and tells the framer to start sending. Every response carries the final bit.

Once an I-frame has gone out, the block keeps the host's transmit path closed until the primary answers. An answer that acknowledges the frame raises an all-sent interrupt and advances the send sequence number. A reject, a repeated N(R), or a poll that brings no new acknowledgement raises a retransmit interrupt. The block never polls the primary. For that reason, the host can start a one-shot recovery timer. When the timer expires while an acknowledgement is outstanding, the host may re-queue the frame.

Top module: `nrm_sec_tx`

## Requirements
- R1: A response starts (`tx_start` high for one cycle, in the cycle after the frame event) only when an accepted frame event is an RR (`rx_type`=0) or an I-frame (`rx_type`=3) with `rx_pf`=1. RNR (`rx_type`=1) and REJ (`rx_type`=2) never count as a poll, and a poll that arrives while a response is being sent is ignored.
- R2: A `host_arm` pulse queues one I-frame only while idle. An armed frame is held until a poll arrives. `host_arm` has no effect while a frame is being sent or while the block is waiting for an acknowledgement.
- R3: Every response has `tx_final`=1. An I-frame response has `tx_kind`=1, and while it is sent `tx_ns` shows V(S) and `tx_nr` shows V(R).
- R4: A poll that finds no frame armed is answered with an RR (`tx_kind`=0, `tx_final`=1), and `tx_nr` shows V(R).
- R5: A frame event is accepted when `rx_addr` equals `cfg_own_addr`, or when it equals `cfg_bcast_addr` and `cfg_bcast_en`=1. Any other event has no effect.
- R6: `tx_path_en` goes low when a response starts. `tx_done` after an RR response returns the block to idle with `tx_path_en` high. `tx_done` after an I-frame leaves `tx_path_en` low until an acknowledgement or a retransmit request arrives.
- R7: While waiting, a non-REJ frame with N(R) = V(S)+1 (mod 2^SEQ_W) sets `irq_all_sent`, increments V(S) and raises `tx_path_en`. The count wraps from 7 to 0 with the default width.
- R8: While waiting, a REJ, an N(R) equal to V(S), or a poll without the acknowledging N(R) sets `irq_retx`, keeps V(S) and raises `tx_path_en`. A poll in that frame is answered with an RR. Any other N(R) that arrives without a poll is ignored.
- R9: V(R) increments by one on each accepted I-frame event.
- R10: `tmr_start` loads `tmr_load`. `irq_timeout` is set at the `tmr_load`-th clock edge after the loading edge, and the expiry transmits nothing. An expiry while waiting moves the block to recovery, where `host_arm` re-queues the frame.
- R11: `irq_all_sent` (`irq_clr` bit 0), `irq_retx` (bit 1) and `irq_timeout` (bit 2) stay set until their own clear bit is written as one. A clear bit has no effect on the other flags.
- R12: With `rst_n` low at a clock edge, the block is idle, V(S), V(R) and the timer are zero, all flags are clear, `tx_start` is low and `tx_path_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One decoded receive frame event this cycle |
| rx_type | input | 2 | Frame kind: 0 RR, 1 RNR, 2 REJ, 3 I |
| rx_pf | input | 1 | Poll bit of the received frame |
| rx_nr | input | SEQ_W | N(R) of the received frame |
| rx_addr | input | ADDR_W | Address field of the received frame |
| cfg_own_addr | input | ADDR_W | Station address |
| cfg_bcast_addr | input | ADDR_W | Broadcast address |
| cfg_bcast_en | input | 1 | Accept broadcast-addressed frames |
| host_arm | input | 1 | Queue one I-frame |
| tx_done | input | 1 | Framer finished the current response |
| tx_start | output | 1 | Start a response now |
| tx_kind | output | 1 | Response kind: 0 RR, 1 I-frame |
| tx_final | output | 1 | Final bit for the response |
| tx_ns | output | SEQ_W | Current V(S) |
| tx_nr | output | SEQ_W | Current V(R) |
| tx_path_en | output | 1 | Host may load the transmit path |
| tmr_start | input | 1 | Load and start the recovery timer |
| tmr_load | input | TMR_W | Timer period in cycles |
| irq_clr | input | 3 | Write-one-to-clear: bit 0 all-sent, bit 1 retransmit, bit 2 timeout |
| irq_all_sent | output | 1 | Frame positively acknowledged |
| irq_retx | output | 1 | Frame must be repeated |
| irq_timeout | output | 1 | Recovery timer expired |

## Verification
On every cycle the assertions check these rules:
- a response starts only one cycle after a polled event, and only as a single-cycle pulse;
- the transmit path closes only when a response starts;
- an all-sent flag rises only together with a one-step advance of V(S);
- a retransmit flag rises only while V(S) holds, and never in the same cycle as an all-sent flag;
- every flag stays set until its own clear bit is written.

Only the bench scenarios can show which poll gets which response kind, and that address filtering works with broadcast enabled and disabled. They also cover arming being ignored while busy, the exact expiry cycle of the timer, recovery by re-queuing, and V(S) wrapping across eight acknowledged frames.

// File: rtl/nrm_sec_pkg.sv
package nrm_sec_pkg;

   typedef enum logic [1:0] {
      FT_RR  = 2'd0,
      FT_RNR = 2'd1,
      FT_REJ = 2'd2,
      FT_I   = 2'd3
   } frm_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_SENDING,
      ST_WAIT_ACK,
      ST_RECOVER
   } st_t;

   localparam int IRQ_ALL  = 0;
   localparam int IRQ_RETX = 1;
   localparam int IRQ_TMO  = 2;
   localparam int IRQ_N    = 3;

endpackage

// File: rtl/nrm_addr_match.sv
module nrm_addr_match #(
   parameter int ADDR_W = 8,
   parameter bit BCAST  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] own,
   input  logic [ADDR_W-1:0] bcast,
   input  logic              bcast_en,
   output logic              hit
);

   generate
      if (BCAST) begin : g_bcast
         assign hit = (addr == own) || (bcast_en && (addr == bcast));
      end else begin : g_own_only
         logic unused_bcast;
         assign unused_bcast = ^{bcast, bcast_en};
         assign hit = (addr == own);
      end
   endgenerate

endmodule

// File: rtl/nrm_seq_cnt.sv
module nrm_seq_cnt #(
   parameter int SEQ_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vs_inc,
   input  logic             vr_inc,
   output logic [SEQ_W-1:0] vs,
   output logic [SEQ_W-1:0] vr
);

   localparam logic [SEQ_W-1:0] ONE = SEQ_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vs <= '0;
         vr <= '0;
      end else begin
         if (vs_inc) vs <= vs + ONE;
         if (vr_inc) vr <= vr + ONE;
      end
   end

endmodule

// File: rtl/nrm_tmr.sv
module nrm_tmr #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TMR_W-1:0] load,
   output logic             expire
);

   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (start)        cnt <= load;
      else if (cnt != '0)    cnt <= cnt - ONE;
   end

   assign expire = !start && (cnt == ONE);

endmodule

// File: rtl/nrm_sec_tx.sv
module nrm_sec_tx
   import nrm_sec_pkg::*;
#(
   parameter int SEQ_W  = 3,
   parameter int ADDR_W = 8,
   parameter int TMR_W  = 16,
   parameter bit BCAST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [1:0]        rx_type,
   input  logic              rx_pf,
   input  logic [SEQ_W-1:0]  rx_nr,
   input  logic [ADDR_W-1:0] rx_addr,
   input  logic [ADDR_W-1:0] cfg_own_addr,
   input  logic [ADDR_W-1:0] cfg_bcast_addr,
   input  logic              cfg_bcast_en,
   input  logic              host_arm,
   input  logic              tx_done,
   output logic              tx_start,
   output logic              tx_kind,
   output logic              tx_final,
   output logic [SEQ_W-1:0]  tx_ns,
   output logic [SEQ_W-1:0]  tx_nr,
   output logic              tx_path_en,
   input  logic              tmr_start,
   input  logic [TMR_W-1:0]  tmr_load,
   input  logic [2:0]        irq_clr,
   output logic              irq_all_sent,
   output logic              irq_retx,
   output logic              irq_timeout
);

   localparam logic [SEQ_W-1:0] SEQ_ONE = SEQ_W'(1);

   generate
      if (SEQ_W < 2)  begin : g_chk_seq  $error("SEQ_W must be at least 2");  end
      if (ADDR_W < 1) begin : g_chk_addr $error("ADDR_W must be positive");   end
      if (TMR_W < 2)  begin : g_chk_tmr  $error("TMR_W must be at least 2");  end
   endgenerate

   st_t              st, st_nxt;
   frm_t             ftype;
   logic             hit, acc, poll;
   logic             is_ack, is_retx;
   logic [SEQ_W-1:0] vs, vr;
   logic             vs_inc, vr_inc;
   logic             tmo;
   logic             start_d, start_i_d, sending_i;
   logic             set_all, set_retx;
   logic [IRQ_N-1:0] irq_q, irq_set;

   assign ftype = frm_t'(rx_type);

   nrm_addr_match #(.ADDR_W(ADDR_W), .BCAST(BCAST)) u_match (
      .addr     (rx_addr),
      .own      (cfg_own_addr),
      .bcast    (cfg_bcast_addr),
      .bcast_en (cfg_bcast_en),
      .hit      (hit)
   );

   nrm_seq_cnt #(.SEQ_W(SEQ_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .vs_inc (vs_inc),
      .vr_inc (vr_inc),
      .vs     (vs),
      .vr     (vr)
   );

   nrm_tmr #(.TMR_W(TMR_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start),
      .load   (tmr_load),
      .expire (tmo)
   );

   assign acc     = rx_valid && hit;
   assign poll    = acc && rx_pf && ((ftype == FT_RR) || (ftype == FT_I));
   assign vr_inc  = acc && (ftype == FT_I);
   assign is_ack  = acc && (ftype != FT_REJ) && (rx_nr == vs + SEQ_ONE);
   assign is_retx = acc && !is_ack && ((ftype == FT_REJ) || (rx_nr == vs) || poll);

   always_comb begin
      st_nxt    = st;
      start_d   = 1'b0;
      start_i_d = 1'b0;
      vs_inc    = 1'b0;
      set_all   = 1'b0;
      set_retx  = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (poll) begin
               start_d   = 1'b1;
               start_i_d = host_arm;
               st_nxt    = ST_SENDING;
            end else if (host_arm) begin
               st_nxt = ST_ARMED;
            end
         end
         ST_ARMED: begin
            if (poll) begin
               start_d   = 1'b1;
               start_i_d = 1'b1;
               st_nxt    = ST_SENDING;
            end
         end
         ST_SENDING: begin
            if (tx_done) st_nxt = sending_i ? ST_WAIT_ACK : ST_IDLE;
         end
         ST_WAIT_ACK, ST_RECOVER: begin
            if (is_ack || is_retx) begin
               vs_inc   = is_ack;
               set_all  = is_ack;
               set_retx = is_retx;
               st_nxt   = ST_IDLE;
               if (poll) begin
                  start_d = 1'b1;
                  st_nxt  = ST_SENDING;
               end
            end else if ((st == ST_WAIT_ACK) && tmo) begin
               st_nxt = ST_RECOVER;
            end else if ((st == ST_RECOVER) && host_arm) begin
               st_nxt = ST_ARMED;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         tx_start  <= 1'b0;
         tx_kind   <= 1'b0;
         tx_final  <= 1'b0;
         sending_i <= 1'b0;
      end else begin
         st       <= st_nxt;
         tx_start <= start_d;
         tx_final <= start_d;
         if (start_d) begin
            tx_kind   <= start_i_d;
            sending_i <= start_i_d;
         end
      end
   end

   assign irq_set[IRQ_ALL]  = set_all;
   assign irq_set[IRQ_RETX] = set_retx;
   assign irq_set[IRQ_TMO]  = tmo;

   generate
      for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
         always_ff @(posedge clk) begin
            if (!rst_n)          irq_q[g] <= 1'b0;
            else if (irq_set[g]) irq_q[g] <= 1'b1;
            else if (irq_clr[g]) irq_q[g] <= 1'b0;
         end
      end
   endgenerate

   assign irq_all_sent = irq_q[IRQ_ALL];
   assign irq_retx     = irq_q[IRQ_RETX];
   assign irq_timeout  = irq_q[IRQ_TMO];
   assign tx_ns        = vs;
   assign tx_nr        = vr;
   assign tx_path_en   = (st == ST_IDLE) || (st == ST_ARMED);

endmodule

// File: rtl/nrm_sec_tx_chk.sv
module nrm_sec_tx_chk #(
   parameter int SEQ_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             rx_pf,
   input logic             tx_start,
   input logic             tx_path_en,
   input logic [SEQ_W-1:0] tx_ns,
   input logic [2:0]       irq_clr,
   input logic             irq_all_sent,
   input logic             irq_retx,
   input logic             irq_timeout
);

   AST_START_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(rx_valid && rx_pf)); // R1
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R1
   AST_PATH_CLOSE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_path_en) |-> tx_start); // R6
   AST_ACK_ADVANCES_VS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_all_sent) |-> (tx_ns == SEQ_W'($past(tx_ns) + 1'b1))); // R7
   AST_RETX_KEEPS_VS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_retx) |-> $stable(tx_ns)); // R8
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !($rose(irq_all_sent) && $rose(irq_retx))); // R8
   AST_STICKY_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_all_sent && !irq_clr[0]) |=> irq_all_sent); // R11
   AST_STICKY_RETX: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_retx && !irq_clr[1]) |=> irq_retx); // R11
   AST_STICKY_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_timeout && !irq_clr[2]) |=> irq_timeout); // R11

endmodule

bind nrm_sec_tx nrm_sec_tx_chk #(.SEQ_W(SEQ_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_valid     (rx_valid),
   .rx_pf        (rx_pf),
   .tx_start     (tx_start),
   .tx_path_en   (tx_path_en),
   .tx_ns        (tx_ns),
   .irq_clr      (irq_clr),
   .irq_all_sent (irq_all_sent),
   .irq_retx     (irq_retx),
   .irq_timeout  (irq_timeout)
);

// File: tb/nrm_sec_tx_tb.sv
`timescale 1ns/1ps
module nrm_sec_tx_tb;

   localparam logic [1:0] T_RR = 2'd0, T_RNR = 2'd1, T_REJ = 2'd2, T_I = 2'd3;
   localparam logic [7:0] OWN = 8'h21, BC = 8'hFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_valid = 1'b0, rx_pf = 1'b0, cfg_bcast_en = 1'b1;
   logic [1:0] rx_type = 2'd0;
   logic [2:0] rx_nr = 3'd0, irq_clr = 3'd0;
   logic [7:0] rx_addr = 8'd0;
   logic host_arm = 1'b0, tx_done = 1'b0, tmr_start = 1'b0;
   logic [15:0] tmr_load = 16'd0;
   logic tx_start, tx_kind, tx_final, tx_path_en;
   logic [2:0] tx_ns, tx_nr;
   logic irq_all_sent, irq_retx, irq_timeout;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   nrm_sec_tx u_dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_type(rx_type),
      .rx_pf(rx_pf), .rx_nr(rx_nr), .rx_addr(rx_addr),
      .cfg_own_addr(OWN), .cfg_bcast_addr(BC), .cfg_bcast_en(cfg_bcast_en),
      .host_arm(host_arm), .tx_done(tx_done), .tx_start(tx_start),
      .tx_kind(tx_kind), .tx_final(tx_final), .tx_ns(tx_ns), .tx_nr(tx_nr),
      .tx_path_en(tx_path_en), .tmr_start(tmr_start), .tmr_load(tmr_load),
      .irq_clr(irq_clr), .irq_all_sent(irq_all_sent), .irq_retx(irq_retx),
      .irq_timeout(irq_timeout)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic frame(input logic [1:0] t, input logic pf, input logic [2:0] nr,
                        input logic [7:0] a);
      @(negedge clk);
      rx_valid = 1'b1; rx_type = t; rx_pf = pf; rx_nr = nr; rx_addr = a;
      @(negedge clk);
      rx_valid = 1'b0; rx_pf = 1'b0;
   endtask

   task automatic arm();
      @(negedge clk); host_arm = 1'b1;
      @(negedge clk); host_arm = 1'b0;
   endtask

   task automatic done();
      @(negedge clk); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
   endtask

   task automatic clr(input logic [2:0] m);
      @(negedge clk); irq_clr = m;
      @(negedge clk); irq_clr = 3'd0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R12 start", tx_start, 0);
      chk("R12 path_en", tx_path_en, 1);
      chk("R12 ns", tx_ns, 0);
      chk("R12 nr", tx_nr, 0);
      chk("R12 irqs", {irq_all_sent, irq_retx, irq_timeout}, 0);
   endtask

   task automatic t_rr_poll();
      frame(T_RR, 1'b1, 3'd0, OWN);
      chk("R4 start", tx_start, 1);
      chk("R4 kind RR", tx_kind, 0);
      chk("R3 final", tx_final, 1);
      chk("R4 nr", tx_nr, 0);
      chk("R6 path closed", tx_path_en, 0);
      done();
      chk("R6 idle after RR", tx_path_en, 1);
   endtask

   task automatic t_no_poll();
      arm();
      frame(T_RR, 1'b0, 3'd0, OWN);
      chk("R2 held without poll", tx_start, 0);
      frame(T_REJ, 1'b1, 3'd0, OWN);
      chk("R1 REJ not a poll", tx_start, 0);
      frame(T_RNR, 1'b1, 3'd0, OWN);
      chk("R1 RNR not a poll", tx_start, 0);
      chk("R2 armed path open", tx_path_en, 1);
   endtask

   task automatic t_addr();
      frame(T_RR, 1'b1, 3'd0, 8'h55);
      chk("R5 foreign addr", tx_start, 0);
      cfg_bcast_en = 1'b0;
      frame(T_RR, 1'b1, 3'd0, BC);
      chk("R5 bcast disabled", tx_start, 0);
      cfg_bcast_en = 1'b1;
      frame(T_RR, 1'b1, 3'd0, BC);
      chk("R5 bcast accepted", tx_start, 1);
      chk("R3 kind I", tx_kind, 1);
      chk("R3 ns", tx_ns, 0);
      chk("R3 final", tx_final, 1);
      frame(T_RR, 1'b1, 3'd0, OWN);
      chk("R1 poll while sending", tx_start, 0);
      done();
      chk("R6 wait ack path", tx_path_en, 0);
      arm();
   endtask

   task automatic t_ack();
      frame(T_RR, 1'b0, 3'd1, OWN);
      chk("R7 all_sent", irq_all_sent, 1);
      chk("R7 no retx", irq_retx, 0);
      chk("R7 ns", tx_ns, 1);
      chk("R7 path", tx_path_en, 1);
      frame(T_RR, 1'b1, 3'd0, OWN);
      chk("R2 arm ignored", tx_kind, 0);
      chk("R2 start", tx_start, 1);
      done();
      clr(3'b001);
      chk("R11 clear all", irq_all_sent, 0);
   endtask

   task automatic t_rej();
      arm();
      frame(T_I, 1'b1, 3'd0, OWN);
      chk("R3 start I", tx_start, 1);
      chk("R3 kind", tx_kind, 1);
      chk("R3 ns", tx_ns, 1);
      chk("R9 vr", tx_nr, 1);
      done();
      frame(T_RR, 1'b0, 3'd5, OWN);
      chk("R8 stray nr ignored", {irq_all_sent, irq_retx}, 0);
      chk("R8 still waiting", tx_path_en, 0);
      frame(T_REJ, 1'b0, 3'd1, OWN);
      chk("R8 retx", irq_retx, 1);
      chk("R8 ns kept", tx_ns, 1);
      chk("R8 no all", irq_all_sent, 0);
      chk("R8 path", tx_path_en, 1);
      clr(3'b010);
      chk("R11 clear retx", irq_retx, 0);
   endtask

   task automatic t_poll_noack();
      arm();
      frame(T_RR, 1'b1, 3'd0, OWN);
      chk("R3 resend I", tx_kind, 1);
      done();
      frame(T_RR, 1'b1, 3'd1, OWN);
      chk("R8 retx on poll", irq_retx, 1);
      chk("R8 RR answer", tx_start, 1);
      chk("R8 RR kind", tx_kind, 0);
      chk("R8 ns kept", tx_ns, 1);
      done();
      clr(3'b001);
      chk("R11 other bit kept", irq_retx, 1);
      clr(3'b010);
      chk("R11 retx cleared", irq_retx, 0);
   endtask

   task automatic t_timer();
      arm();
      frame(T_RR, 1'b1, 3'd0, OWN);
      done();
      @(negedge clk); tmr_start = 1'b1; tmr_load = 16'd5;
      @(negedge clk); tmr_start = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 not yet", irq_timeout, 0);
      @(negedge clk);
      chk("R10 expired", irq_timeout, 1);
      chk("R10 silent", tx_start, 0);
      chk("R10 path still closed", tx_path_en, 0);
      arm();
      chk("R10 rearmed", tx_path_en, 1);
      frame(T_I, 1'b1, 3'd0, OWN);
      chk("R10 repeat I", tx_kind, 1);
      chk("R10 repeat ns", tx_ns, 1);
      chk("R9 vr", tx_nr, 2);
      done();
      frame(T_RR, 1'b0, 3'd2, OWN);
      chk("R7 ack", tx_ns, 2);
      clr(3'b111);
      chk("R11 clear all", {irq_all_sent, irq_retx, irq_timeout}, 0);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 8; i++) begin
         logic [2:0] exp_ns;
         exp_ns = 3'(2 + i + 1);
         arm();
         frame(T_RR, 1'b1, 3'd0, OWN);
         done();
         frame(T_RR, 1'b0, exp_ns, OWN);
         chk("R7 wrap ns", tx_ns, exp_ns);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_rr_poll();
      t_no_poll();
      t_addr();
      t_ack();
      t_rej();
      t_poll_noack();
      t_timer();
      t_wrap();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule